// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs the core side of one coprocessor operation. The operation is one of five kinds: a register transfer into the coprocessor, a register transfer out of it, an internal calculation, a multi-word load from memory into the coprocessor, or a multi-word store from the coprocessor to memory. After a start request the block checks that the selected coprocessor may be used. It then drives a phase code to that coprocessor and reacts to the response code that comes back in the same cycle.

A busy response makes the block wait one idle cycle and ask again. It abandons the operation if an interrupt is pending during that idle cycle. A refusal ends the operation with an undefined-instruction trap. Bursts read or write one word per DATA phase and advance the address by four bytes for as long as the coprocessor answers "increment". Each operation ends with exactly one one-cycle outcome pulse: done, undefined trap, data abort or interrupt exit. Writeback of the base register belongs to the caller.

Top module: `cop_seq`

## Requirements
- R1: Codes on the phase port are NONE=0, FIRST=1, BUSY=2, INTERRUPT=3, TRANSFER=4 and DATA=5. Codes on the response port are BUSY=0, CANT=1, INC=2 and DONE=3. Operation codes are TO=0, FROM=1, CALC=2, LOAD=3 and STORE=4. An accepted start presents FIRST in the next cycle, and cp_wdata_o carries the latched wdata_i in that cycle.
- R2: A start whose cp_allow_i bit for cp_num_i is clear gives an undef_o pulse in the next cycle, and no phase is ever presented.
- R3: A BUSY response to FIRST or BUSY is followed by one idle cycle (idle_o). If no interrupt is pending in that idle cycle, a BUSY phase follows.
- R4: An interrupt pending in a busy-wait idle cycle causes one INTERRUPT phase in the next cycle, then an irq_exit_o pulse, with no trap and no memory access.
- R5: A CANT response to FIRST or BUSY gives an undef_o pulse in the next cycle. For a FROM operation, result_o becomes the flags-preserving constant 0xF000_0000.
- R6: A LOAD presents TRANSFER, then DATA with mem_rd_o at the start address. In each DATA cycle cp_wdata_o equals mem_rdata_i. Each INC response repeats DATA at the address plus 4.
- R7: A STORE presents DATA with mem_wr_o and mem_wdata_o equal to cp_rdata_i at the start address. Each INC response repeats DATA at the address plus 4.
- R8: After DONE or INC, a TO operation spends one coprocessor cycle (cop_cyc_o) and then pulses done_o. A FROM operation spends one coprocessor cycle and one idle cycle before done_o, and result_o holds the cp_rdata_i value seen with that response.
- R9: A CALC operation pulses done_o in the cycle after DONE.
- R10: A LOAD or STORE whose start address has any bit at or above bit 26 set, or a STORE below byte address 32, still runs its burst but ends with dabort_o instead of done_o.
- R11: mem_abort_i high during any burst access makes the burst end with dabort_o.
- R12: busy_o is high from the cycle after acceptance through the outcome pulse cycle and then drops. start_i has no effect while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| op_i | input | 3 | Operation code |
| cp_num_i | input | CP_W | Coprocessor number |
| cp_allow_i | input | CP_N | Access permission, one bit per coprocessor |
| addr_i | input | ADDR_W | Burst start address |
| wdata_i | input | DATA_W | Register value for a TO transfer |
| irq_pend_i | input | 1 | Interrupt pending |
| busy_o | output | 1 | Operation in progress |
| phase_vld_o | output | 1 | Phase code valid |
| phase_o | output | 3 | Phase code |
| cp_sel_o | output | CP_W | Selected coprocessor |
| cp_wdata_o | output | DATA_W | Data to coprocessor |
| resp_i | input | 2 | Response code, same cycle as the phase |
| cp_rdata_i | input | DATA_W | Data from coprocessor |
| mem_rd_o | output | 1 | Memory word read |
| mem_wr_o | output | 1 | Memory word write |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, same cycle |
| mem_abort_i | input | 1 | Abort for the current access |
| idle_o | output | 1 | Idle cycle spent |
| cop_cyc_o | output | 1 | Coprocessor cycle spent |
| result_o | output | DATA_W | Value from a FROM transfer |
| done_o | output | 1 | Outcome pulse: completed |
| undef_o | output | 1 | Outcome pulse: undefined-instruction trap |
| dabort_o | output | 1 | Outcome pulse: data abort |
| irq_exit_o | output | 1 | Outcome pulse: abandoned for interrupt |

## Verification
An interrupt request and a coprocessor answer can arrive in the same cycle. The block samples the interrupt only in the idle cycle of a busy wait. So an interrupt that is pending while FIRST or BUSY gets a DONE or BUSY answer must neither abandon the operation nor alter the burst. The bench holds irq_pend_i high in every phase cycle of a calculation and of a store burst, each with a busy wait. The cycle-by-cycle reference then expects a normal completion. A separate run raises the interrupt only in the idle cycle and expects the INTERRUPT phase and the exit pulse.

// File: rtl/cop_seq_pkg.sv
package cop_seq_pkg;

  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_FIRST = 3'd1,
    PH_BUSY  = 3'd2,
    PH_INTR  = 3'd3,
    PH_XFER  = 3'd4,
    PH_DATA  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    RS_BUSY = 2'd0,
    RS_CANT = 2'd1,
    RS_INC  = 2'd2,
    RS_DONE = 2'd3
  } resp_e;

  typedef enum logic [2:0] {
    OP_TO    = 3'd0,
    OP_FROM  = 3'd1,
    OP_CALC  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    TK_DONE   = 2'd0,
    TK_UNDEF  = 2'd1,
    TK_DABORT = 2'd2,
    TK_IRQ    = 2'd3
  } term_e;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_FIRST = 4'd1,
    ST_WAIT  = 4'd2,
    ST_REPH  = 4'd3,
    ST_INTR  = 4'd4,
    ST_XFER  = 4'd5,
    ST_LDATA = 4'd6,
    ST_SDATA = 4'd7,
    ST_CCYC  = 4'd8,
    ST_ICYC  = 4'd9,
    ST_END   = 4'd10
  } state_e;

endpackage

// File: rtl/cop_seq_screen.sv
module cop_seq_screen #(
  parameter int ADDR_W    = 32,
  parameter int CP_N      = 16,
  parameter int OK_ADDR_W = 26,
  parameter int VEC_BYTES = 32,
  localparam int CP_W     = $clog2(CP_N)
) (
  input  logic [CP_W-1:0]   cp_num_i,
  input  logic [CP_N-1:0]   cp_allow_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        op_i,
  output logic              allow_o,
  output logic              exc_o
);
  import cop_seq_pkg::*;

  logic hi_bits;
  logic in_vec;
  logic is_ld;
  logic is_st;

  assign allow_o = cp_allow_i[cp_num_i];

  generate
    if (OK_ADDR_W < ADDR_W) begin : g_range
      assign hi_bits = |addr_i[ADDR_W-1:OK_ADDR_W];
    end else begin : g_full
      assign hi_bits = 1'b0;
    end
  endgenerate

  assign in_vec = addr_i < ADDR_W'(VEC_BYTES);
  assign is_ld  = op_i == OP_LOAD;
  assign is_st  = op_i == OP_STORE;
  assign exc_o  = (is_ld & hi_bits) | (is_st & (hi_bits | in_vec));

endmodule

// File: rtl/cop_seq_addr.sv
module cop_seq_addr #(
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              exc_i,
  input  logic              step_i,
  input  logic              access_i,
  input  logic              mem_abort_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              abort_any_o
);

  logic [ADDR_W-1:0] addr_q;
  logic              abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      if (load_i)      addr_q <= start_addr_i;
      else if (step_i) addr_q <= addr_q + ADDR_W'(STEP_BYTES);
      if (load_i)                      abort_q <= exc_i;
      else if (access_i & mem_abort_i) abort_q <= 1'b1;
    end
  end

  assign addr_o      = addr_q;
  // includes the access in flight so the last word counts
  assign abort_any_o = abort_q | (access_i & mem_abort_i);

endmodule

// File: rtl/cop_seq_ctrl.sv
module cop_seq_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       allow_i,
  input  logic [2:0] op_i,
  input  logic [1:0] resp_i,
  input  logic       irq_pend_i,
  input  logic       abort_any_i,
  output logic       accept_o,
  output logic       busy_o,
  output logic       phase_vld_o,
  output logic [2:0] phase_o,
  output logic       idle_o,
  output logic       cop_cyc_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       step_o,
  output logic       cap_o,
  output logic       keep_o,
  output logic       done_o,
  output logic       undef_o,
  output logic       dabort_o,
  output logic       irq_exit_o
);
  import cop_seq_pkg::*;

  state_e state_q, state_d;
  term_e  kind_q, kind_d;
  op_e    op_q;
  resp_e  rsp;

  assign rsp = resp_e'(resp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= TK_DONE;
      op_q    <= OP_TO;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      if (accept_o) op_q <= op_e'(op_i);
    end
  end

  always_comb begin
    state_d     = state_q;
    kind_d      = kind_q;
    accept_o    = 1'b0;
    phase_vld_o = 1'b0;
    phase_o     = PH_NONE;
    idle_o      = 1'b0;
    cop_cyc_o   = 1'b0;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    step_o      = 1'b0;
    cap_o       = 1'b0;
    keep_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = allow_i;
          if (allow_i) begin
            state_d = ST_FIRST;
          end else begin
            state_d = ST_END;
            kind_d  = TK_UNDEF;
          end
        end
      end
      ST_FIRST, ST_REPH: begin
        phase_vld_o = 1'b1;
        phase_o     = (state_q == ST_FIRST) ? PH_FIRST : PH_BUSY;
        unique case (rsp)
          RS_BUSY: state_d = ST_WAIT;
          RS_CANT: begin
            state_d = ST_END;
            kind_d  = TK_UNDEF;
            keep_o  = (op_q == OP_FROM);
          end
          default: begin
            cap_o = (op_q == OP_FROM);
            unique case (op_q)
              OP_TO, OP_FROM: state_d = ST_CCYC;
              OP_LOAD:        state_d = ST_XFER;
              OP_STORE:       state_d = ST_SDATA;
              default: begin
                state_d = ST_END;
                kind_d  = TK_DONE;
              end
            endcase
          end
        endcase
      end
      ST_WAIT: begin
        idle_o  = 1'b1;
        state_d = irq_pend_i ? ST_INTR : ST_REPH;
      end
      ST_INTR: begin
        phase_vld_o = 1'b1;
        phase_o     = PH_INTR;
        state_d     = ST_END;
        kind_d      = TK_IRQ;
      end
      ST_XFER: begin
        phase_vld_o = 1'b1;
        phase_o     = PH_XFER;
        state_d     = ST_LDATA;
      end
      ST_LDATA, ST_SDATA: begin
        phase_vld_o = 1'b1;
        phase_o     = PH_DATA;
        mem_rd_o    = (state_q == ST_LDATA);
        mem_wr_o    = (state_q == ST_SDATA);
        if (rsp == RS_INC) begin
          step_o = 1'b1;
        end else begin
          state_d = ST_END;
          kind_d  = abort_any_i ? TK_DABORT : TK_DONE;
        end
      end
      ST_CCYC: begin
        cop_cyc_o = 1'b1;
        if (op_q == OP_FROM) begin
          state_d = ST_ICYC;
        end else begin
          state_d = ST_END;
          kind_d  = TK_DONE;
        end
      end
      ST_ICYC: begin
        idle_o  = 1'b1;
        state_d = ST_END;
        kind_d  = TK_DONE;
      end
      ST_END:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy_o     = state_q != ST_IDLE;
  assign done_o     = (state_q == ST_END) && (kind_q == TK_DONE);
  assign undef_o    = (state_q == ST_END) && (kind_q == TK_UNDEF);
  assign dabort_o   = (state_q == ST_END) && (kind_q == TK_DABORT);
  assign irq_exit_o = (state_q == ST_END) && (kind_q == TK_IRQ);

endmodule

// File: rtl/cop_seq.sv
module cop_seq #(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          CP_N       = 16,
  parameter int          OK_ADDR_W  = 26,
  parameter int          VEC_BYTES  = 32,
  parameter int          STEP_BYTES = 4,
  parameter logic [31:0] FLAGS_KEEP = 32'hF000_0000,
  localparam int         CP_W       = $clog2(CP_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [CP_W-1:0]   cp_num_i,
  input  logic [CP_N-1:0]   cp_allow_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_pend_i,
  output logic              busy_o,
  output logic              phase_vld_o,
  output logic [2:0]        phase_o,
  output logic [CP_W-1:0]   cp_sel_o,
  output logic [DATA_W-1:0] cp_wdata_o,
  input  logic [1:0]        resp_i,
  input  logic [DATA_W-1:0] cp_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_abort_i,
  output logic              idle_o,
  output logic              cop_cyc_o,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o,
  output logic              undef_o,
  output logic              dabort_o,
  output logic              irq_exit_o
);

  logic              allow;
  logic              start_exc;
  logic              accept;
  logic              step;
  logic              cap;
  logic              keep;
  logic              abort_any;
  logic [CP_W-1:0]   cp_sel_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] result_q;

  cop_seq_screen #(
    .ADDR_W    (ADDR_W),
    .CP_N      (CP_N),
    .OK_ADDR_W (OK_ADDR_W),
    .VEC_BYTES (VEC_BYTES)
  ) u_screen (
    .cp_num_i   (cp_num_i),
    .cp_allow_i (cp_allow_i),
    .addr_i     (addr_i),
    .op_i       (op_i),
    .allow_o    (allow),
    .exc_o      (start_exc)
  );

  cop_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .allow_i     (allow),
    .op_i        (op_i),
    .resp_i      (resp_i),
    .irq_pend_i  (irq_pend_i),
    .abort_any_i (abort_any),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .phase_vld_o (phase_vld_o),
    .phase_o     (phase_o),
    .idle_o      (idle_o),
    .cop_cyc_o   (cop_cyc_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .step_o      (step),
    .cap_o       (cap),
    .keep_o      (keep),
    .done_o      (done_o),
    .undef_o     (undef_o),
    .dabort_o    (dabort_o),
    .irq_exit_o  (irq_exit_o)
  );

  cop_seq_addr #(
    .ADDR_W     (ADDR_W),
    .STEP_BYTES (STEP_BYTES)
  ) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (accept),
    .start_addr_i (addr_i),
    .exc_i        (start_exc),
    .step_i       (step),
    .access_i     (mem_rd_o | mem_wr_o),
    .mem_abort_i  (mem_abort_i),
    .addr_o       (mem_addr_o),
    .abort_any_o  (abort_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cp_sel_q <= '0;
      wdata_q  <= '0;
      result_q <= '0;
    end else begin
      if (accept) begin
        cp_sel_q <= cp_num_i;
        wdata_q  <= wdata_i;
      end
      if (keep)     result_q <= DATA_W'(FLAGS_KEEP);
      else if (cap) result_q <= cp_rdata_i;
    end
  end

  assign cp_sel_o    = cp_sel_q;
  assign cp_wdata_o  = mem_rd_o ? mem_rdata_i : wdata_q;
  assign mem_wdata_o = cp_rdata_i;
  assign result_o    = result_q;

endmodule

// File: rtl/cop_seq_chk.sv
module cop_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int CP_N       = 16,
  parameter int STEP_BYTES = 4,
  localparam int CP_W      = $clog2(CP_N)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic [CP_W-1:0]   cp_num_i,
  input logic [CP_N-1:0]   cp_allow_i,
  input logic              phase_vld_o,
  input logic [2:0]        phase_o,
  input logic [1:0]        resp_i,
  input logic              irq_pend_i,
  input logic              idle_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              undef_o,
  input logic              irq_exit_o
);
  import cop_seq_pkg::*;

  logic ask_ph;
  assign ask_ph = phase_vld_o && ((phase_o == PH_FIRST) || (phase_o == PH_BUSY));

  assert_deny_trap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !cp_allow_i[cp_num_i]) |=> (undef_o && !phase_vld_o));

  assert_busy_idles_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ask_ph && resp_i == RS_BUSY) |=> idle_o);

  assert_busy_reasks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !irq_pend_i && $past(phase_vld_o)) |=> (phase_vld_o && phase_o == PH_BUSY));

  assert_irq_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && irq_pend_i && $past(phase_vld_o)) |=> (phase_vld_o && phase_o == PH_INTR));

  assert_irq_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_vld_o && phase_o == PH_INTR) |=> (irq_exit_o && !undef_o));

  assert_cant_trap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ask_ph && resp_i == RS_CANT) |=> undef_o);

  assert_mem_in_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> (phase_vld_o && phase_o == PH_DATA && !(mem_rd_o && mem_wr_o)));

  assert_addr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_vld_o && phase_o == PH_DATA && resp_i == RS_INC)
      |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(STEP_BYTES)));

endmodule

bind cop_seq cop_seq_chk #(
  .ADDR_W     (ADDR_W),
  .CP_N       (CP_N),
  .STEP_BYTES (STEP_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .cp_num_i    (cp_num_i),
  .cp_allow_i  (cp_allow_i),
  .phase_vld_o (phase_vld_o),
  .phase_o     (phase_o),
  .resp_i      (resp_i),
  .irq_pend_i  (irq_pend_i),
  .idle_o      (idle_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_addr_o  (mem_addr_o),
  .undef_o     (undef_o),
  .irq_exit_o  (irq_exit_o)
);

// File: tb/cop_seq_tb.sv
module cop_seq_tb;
  import cop_seq_pkg::*;

  localparam int          CLK_P    = 10;
  localparam logic [31:0] FROM_VAL = 32'h1234_5678;
  localparam logic [31:0] KEEP_VAL = 32'hF000_0000;
  localparam logic [15:0] ALLOW    = 16'hFFDF;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [2:0]  op_i;
  logic [3:0]  cp_num_i;
  logic [15:0] cp_allow_i;
  logic [31:0] addr_i;
  logic [31:0] wdata_i;
  logic        irq_pend_i;
  logic        busy_o;
  logic        phase_vld_o;
  logic [2:0]  phase_o;
  logic [3:0]  cp_sel_o;
  logic [31:0] cp_wdata_o;
  logic [1:0]  resp_i;
  logic [31:0] cp_rdata_i;
  logic        mem_rd_o;
  logic        mem_wr_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata_i;
  logic        mem_abort_i;
  logic        idle_o;
  logic        cop_cyc_o;
  logic [31:0] result_o;
  logic        done_o;
  logic        undef_o;
  logic        dabort_o;
  logic        irq_exit_o;

  cop_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .cp_num_i(cp_num_i), .cp_allow_i(cp_allow_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .irq_pend_i(irq_pend_i), .busy_o(busy_o),
    .phase_vld_o(phase_vld_o), .phase_o(phase_o), .cp_sel_o(cp_sel_o),
    .cp_wdata_o(cp_wdata_o), .resp_i(resp_i), .cp_rdata_i(cp_rdata_i),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_abort_i(mem_abort_i), .idle_o(idle_o), .cop_cyc_o(cop_cyc_o),
    .result_o(result_o), .done_o(done_o), .undef_o(undef_o),
    .dabort_o(dabort_o), .irq_exit_o(irq_exit_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [1:0] rq[$];
  int   irq_at    = -1;
  logic irq_on_ph = 1'b0;
  int   abort_at  = -1;
  logic poke      = 1'b0;

  logic        e_pv, e_rd, e_wr, e_idle, e_cc, e_busy, e_cw_en, e_md_en;
  logic [2:0]  e_ph;
  logic [3:0]  e_term;
  logic [31:0] e_addr, e_cw, e_md;

  task automatic clr();
    e_pv = 0; e_rd = 0; e_wr = 0; e_idle = 0; e_cc = 0; e_busy = 1;
    e_cw_en = 0; e_md_en = 0; e_ph = PH_NONE; e_term = 4'b0000;
    e_addr = '0; e_cw = '0; e_md = '0;
  endtask

  task automatic tick();
    @(negedge clk_i);
    start_i = 1'b0; irq_pend_i = 1'b0; mem_abort_i = 1'b0;
  endtask

  task automatic chk(input string tag);
    logic [12:0] act, exp;
    logic ok;
    #1;
    act = {phase_vld_o, phase_o, mem_rd_o, mem_wr_o, idle_o, cop_cyc_o, busy_o,
           done_o, undef_o, dabort_o, irq_exit_o};
    exp = {e_pv, e_ph, e_rd, e_wr, e_idle, e_cc, e_busy, e_term};
    ok = (act == exp);
    if (e_rd || e_wr) ok = ok && (mem_addr_o == e_addr);
    if (e_cw_en) ok = ok && (cp_wdata_o == e_cw);
    if (e_md_en) ok = ok && (mem_wdata_o == e_md);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h/%h/%h/%h expected=%h/%h/%h/%h", tag, act, mem_addr_o,
               cp_wdata_o, mem_wdata_o, exp, e_addr, e_cw, e_md);
    end
  endtask

  task automatic chk_res(input logic [31:0] exp, input string tag);
    n_chk++;
    if (result_o !== exp) begin
      n_fail++;
      $display("FAIL %s result: actual=%h expected=%h", tag, result_o, exp);
    end
  endtask

  function automatic logic [1:0] pop();
    if (rq.size() == 0) return RS_DONE;
    return rq.pop_front();
  endfunction

  task automatic finish_op(input string tag);
    tick(); clr(); e_busy = 0; chk({tag, " R12 back to idle"});
  endtask

  task automatic run_op(input string tag, input logic [2:0] op, input logic [3:0] cp,
                        input logic [31:0] a, input logic [31:0] wd);
    logic [1:0]  r;
    logic [31:0] ea;
    logic        abo, hi, is_ld;
    int          nb;
    int          w;
    ea = a;
    hi = |a[31:26];
    is_ld = (op == OP_LOAD);
    abo = (is_ld && hi) || ((op == OP_STORE) && (hi || a < 32));
    tick();
    start_i = 1'b1; op_i = op; cp_num_i = cp; addr_i = a; wdata_i = wd;
    resp_i = RS_DONE; cp_rdata_i = '0;
    clr(); e_busy = 0; chk({tag, " R12 idle before start"});
    tick();
    start_i = poke; op_i = OP_CALC; addr_i = 32'h0; wdata_i = 32'h0;
    if (!ALLOW[cp]) begin
      clr(); e_term = 4'b0100; chk({tag, " R2 denied"});
      finish_op(tag);
      return;
    end
    r = pop(); resp_i = r; irq_pend_i = irq_on_ph;
    cp_rdata_i = (op == OP_FROM) ? FROM_VAL : 32'h0;
    clr(); e_pv = 1; e_ph = PH_FIRST; e_cw_en = 1; e_cw = wd; chk({tag, " R1 first phase"});
    nb = 0;
    while (r == RS_BUSY) begin
      tick(); irq_pend_i = (nb == irq_at);
      clr(); e_idle = 1; chk({tag, " R3 idle cycle"});
      if (nb == irq_at) begin
        tick(); clr(); e_pv = 1; e_ph = PH_INTR; chk({tag, " R4 interrupt phase"});
        tick(); clr(); e_term = 4'b0001; chk({tag, " R4 exit pulse"});
        finish_op(tag);
        return;
      end
      nb++;
      tick(); irq_pend_i = irq_on_ph; r = pop(); resp_i = r;
      clr(); e_pv = 1; e_ph = PH_BUSY; chk({tag, " R3 busy phase"});
    end
    if (r == RS_CANT) begin
      tick(); clr(); e_term = 4'b0100; chk({tag, " R5 refusal trap"});
      if (op == OP_FROM) chk_res(KEEP_VAL, {tag, " R5"});
      finish_op(tag);
      return;
    end
    case (op)
      OP_TO: begin
        tick(); clr(); e_cc = 1; chk({tag, " R8 cop cycle"});
        tick(); clr(); e_term = 4'b1000; chk({tag, " R8 done"});
      end
      OP_FROM: begin
        tick(); clr(); e_cc = 1; chk({tag, " R8 cop cycle"});
        tick(); clr(); e_idle = 1; chk({tag, " R8 idle cycle"});
        tick(); clr(); e_term = 4'b1000; chk({tag, " R8 done"});
        chk_res(FROM_VAL, {tag, " R8"});
      end
      OP_LOAD, OP_STORE: begin
        if (is_ld) begin
          tick(); resp_i = RS_DONE; clr(); e_pv = 1; e_ph = PH_XFER; chk({tag, " R6 transfer"});
        end
        w = 0;
        do begin
          tick(); irq_pend_i = irq_on_ph;
          mem_abort_i = (w == abort_at);
          if (w == abort_at) abo = 1'b1;
          mem_rdata_i = 32'hA500_0000 + w;
          cp_rdata_i  = 32'hC0DE_0000 + w;
          r = pop(); resp_i = r;
          clr(); e_pv = 1; e_ph = PH_DATA; e_addr = ea;
          if (is_ld) begin
            e_rd = 1; e_cw_en = 1; e_cw = mem_rdata_i;
            chk({tag, " R6 load word"});
          end else begin
            e_wr = 1; e_md_en = 1; e_md = cp_rdata_i;
            chk({tag, " R7 store word"});
          end
          if (r == RS_INC) ea = ea + 32'd4;
          w++;
        end while (r == RS_INC);
        tick(); clr(); e_term = abo ? 4'b0010 : 4'b1000;
        chk({tag, abo ? " R10 R11 abort outcome" : " burst done"});
      end
      default: begin
        tick(); clr(); e_term = 4'b1000; chk({tag, " R9 done"});
      end
    endcase
    finish_op(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 0; start_i = 0; op_i = '0; cp_num_i = '0; cp_allow_i = ALLOW;
    addr_i = '0; wdata_i = '0; irq_pend_i = 0; resp_i = RS_DONE;
    cp_rdata_i = '0; mem_rdata_i = '0; mem_abort_i = 0;
    repeat (3) @(negedge clk_i);
    clr(); e_busy = 0; chk("R12 reset state");
    chk_res(32'h0, "R12 reset");
    rst_ni = 1;

    rq = '{}; run_op("R8 to", OP_TO, 4'd1, 32'h0, 32'hDEAD_BEEF);
    poke = 1; rq = '{RS_BUSY, RS_BUSY, RS_DONE};
    run_op("R3 R12 from busy", OP_FROM, 4'd2, 32'h0, 32'h1111_0000);
    poke = 0;
    rq = '{RS_DONE}; run_op("R9 calc", OP_CALC, 4'd3, 32'h0, 32'h0);
    rq = '{}; run_op("R2 denied", OP_CALC, 4'd5, 32'h0, 32'h0);
    irq_at = 1; rq = '{RS_BUSY, RS_BUSY, RS_DONE};
    run_op("R4 irq", OP_LOAD, 4'd4, 32'h100, 32'h0);
    irq_at = -1;
    rq = '{RS_CANT}; run_op("R5 from cant", OP_FROM, 4'd6, 32'h0, 32'h0);
    rq = '{RS_BUSY, RS_CANT}; run_op("R5 calc cant", OP_CALC, 4'd7, 32'h0, 32'h0);
    rq = '{RS_DONE, RS_INC, RS_INC, RS_DONE};
    run_op("R6 load", OP_LOAD, 4'd8, 32'h100, 32'h0);
    rq = '{RS_DONE, RS_INC, RS_DONE};
    run_op("R7 store", OP_STORE, 4'd9, 32'h200, 32'h0);
    rq = '{RS_DONE, RS_INC, RS_DONE};
    run_op("R10 load high addr", OP_LOAD, 4'd10, 32'h0400_0000, 32'h0);
    rq = '{RS_DONE, RS_DONE};
    run_op("R10 store vector", OP_STORE, 4'd11, 32'h10, 32'h0);
    abort_at = 1; rq = '{RS_DONE, RS_INC, RS_INC, RS_DONE};
    run_op("R11 load mem abort", OP_LOAD, 4'd12, 32'h300, 32'h0);
    abort_at = -1;
    irq_on_ph = 1; rq = '{RS_BUSY, RS_DONE};
    run_op("R4 irq with answer calc", OP_CALC, 4'd13, 32'h0, 32'h0);
    rq = '{RS_BUSY, RS_DONE, RS_INC, RS_DONE};
    run_op("R7 irq with answer store", OP_STORE, 4'd14, 32'h400, 32'h0);
    irq_on_ph = 0;

    finished = 1;
    summary();
    $finish;
  end

endmodule